// File: doc/BRIEF.md
# Subpage ECC Buffer Sequencer

This block steps one flash page through a 528-byte staging buffer, one 512-byte subpage at a time. A host reaches it through a single access channel that selects either the buffer port or one of three trigger registers: open-encode, auto-encode and auto-decode. On the write side the host opens a subpage, streams 128 data words into the buffer port, adds one 32-bit and one 16-bit spare write, then fires auto-encode. A stub codec with a fixed latency then appends ten parity bytes to the spare area.

On the read side the host fires auto-decode, waits for controller-ready and drains 128 data words followed by 4 spare words. The decode works on whatever the buffer holds, so a write step followed by a read step is a loopback. The stub codec does not correct anything. It reports a correction status taken from an injected error count, so that every status encoding can be reached. A subpage counter advances on each completed step and wraps at the end of the page.

Top module: `sps_seq`

## Requirements
- R1: After reset, ctl_ready is 1, overrun, err_detect and dec_fail are 0, err_count is 0 and sub_idx is 0.
- R2: An open-encode trigger (acc_sel=1) drops ctl_ready, which stays low through the fill. An auto-encode trigger (acc_sel=2) with acc_wdata bit 8 clear starts parity generation, and ctl_ready returns exactly CODEC_LAT (16) cycles after that trigger.
- R3: An auto-encode trigger with acc_wdata bit 8 set is ignored: ctl_ready stays low and no parity is produced.
- R4: An auto-decode trigger (acc_sel=3) drops ctl_ready, which is low for exactly CODEC_LAT cycles after the trigger edge.
- R5: After a decode, buffer reads (acc_sel=0, acc_write=0) return the 128 data words in write order, then 4 spare words. Spare bytes are little-endian within words. Bytes 0..3 hold the spare word, bytes 4..5 hold the low half of the half-word write, and byte 6+k (k=0..9) holds parity k = X[8*(k mod 4)+:8] ^ k ^ 8'hA5, where X is the XOR of the 128 data words.
- R6: A decode reports from inj_errs sampled at its trigger. A value of 0 gives no flags. A value n of 1 to 4 gives err_detect=1 with err_count=n-1. A value of 5 or more gives dec_fail=1 with err_detect=0. The status holds until the next accepted trigger, which clears it.
- R7: A buffer-port access beyond the expected count, or outside a fill or drain, sets a sticky overrun flag and changes neither the buffer contents nor the position. Any accepted trigger clears the flag.
- R8: In a fill, the 129th buffer write must be a full word (acc_half=0) and the 130th must be a half-word (acc_half=1). A mismatched width sets overrun and the write is ignored.
- R9: Triggers that do not fit the current phase are ignored. This covers a decode or open-encode during a fill or during codec busy, and an auto-encode outside a fill.
- R10: sub_idx increments on each completed encode or decode step and wraps to 0 after PAGE_BYTES/512 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 buffer port, 1 open-encode, 2 auto-encode, 3 auto-decode |
| acc_half | input | 1 | Buffer write carries only 16 bits |
| acc_wdata | input | 32 | Write data; bit 8 qualifies auto-encode |
| acc_rdata | output | 32 | Buffer read data for the current drain position |
| inj_errs | input | 3 | Test-mode error count applied to the next decode |
| ctl_ready | output | 1 | Controller ready |
| overrun | output | 1 | Sticky misuse flag |
| err_detect | output | 1 | Decode corrected errors |
| err_count | output | 2 | Corrected symbol count minus one |
| dec_fail | output | 1 | Decode uncorrectable |
| sub_idx | output | SUBW | Current subpage within the page |

## Verification
The bench goes after the ready window. A design that is off by one in its latency timer reopens ready a cycle early or late, and a design that accepts auto-encode with bit 8 set raises ready after a fill that should stay pending. It sweeps injected counts 0 to 5 through the status encoding, where a design that gets this wrong reports failure as a correction or the wrong count. It also checks the spare byte placement, where swapping the half-word and parity positions corrupts spare words 1 to 3. Overrun cases include an extra read, a write during drain and wrong-width spare writes. A design that let these through would advance the drain pointer or overwrite stored bytes.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int DATA_WORDS  = 128;
  localparam int SPARE_WORDS = 4;
  localparam int SUB_WORDS   = DATA_WORDS + SPARE_WORDS;
  localparam int FREE_BYTES  = 6;
  localparam int PAR_BYTES   = 10;
  localparam int SUB_BYTES   = SUB_WORDS * 4;
  localparam int CNTW        = $clog2(SUB_WORDS + 1);

  typedef enum logic [1:0] {
    SEL_BUF  = 2'd0,
    SEL_OPEN = 2'd1,
    SEL_ENC  = 2'd2,
    SEL_DEC  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BUSY,
    ST_DRAIN
  } st_e;
endpackage

// File: rtl/sps_buffer.sv
module sps_buffer
  import sps_pkg::*;
(
  input  logic                      clk,
  input  logic                      we_word,
  input  logic                      we_half,
  input  logic [CNTW-1:0]           idx,
  input  logic [31:0]               wdata,
  input  logic                      par_we,
  input  logic [PAR_BYTES*8-1:0]    parity,
  output logic [31:0]               rdata
);
  localparam int PAR_BASE = DATA_WORDS * 4 + FREE_BYTES;

  logic [7:0] mem [SUB_BYTES];
  int         base;

  always_comb begin
    base = (int'(idx) < SUB_WORDS) ? int'(idx) * 4 : 0;
  end

  always_ff @(posedge clk) begin
    if (we_word) begin
      for (int b = 0; b < 4; b++) mem[base + b] <= wdata[8*b +: 8];
    end
    if (we_half) begin
      for (int b = 0; b < 2; b++) mem[base + b] <= wdata[8*b +: 8];
    end
    if (par_we) begin
      for (int k = 0; k < PAR_BYTES; k++) mem[PAR_BASE + k] <= parity[8*k +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) rdata[8*b +: 8] = mem[base + b];
  end
endmodule

// File: rtl/sps_codec_stub.sv
module sps_codec_stub
  import sps_pkg::*;
#(
  parameter int CODEC_LAT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_acc,
  input  logic                   data_strobe,
  input  logic [31:0]            data_word,
  input  logic                   start_enc,
  input  logic                   start_dec,
  input  logic [2:0]             inj_errs,
  input  logic                   clr_stat,
  output logic                   done,
  output logic [PAR_BYTES*8-1:0] parity,
  output logic                   err_detect,
  output logic [1:0]             err_count,
  output logic                   dec_fail
);
  localparam int TW = (CODEC_LAT > 1) ? $clog2(CODEC_LAT) : 1;

  logic [31:0]   acc_q, acc_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          run_q, run_n;
  logic          mdec_q, mdec_n;
  logic [2:0]    inj_q, inj_n;
  logic          det_q, det_n, fail_q, fail_n;
  logic [1:0]    cnt_q, cnt_n;

  assign done = run_q && (tmr_q == '0);

  generate
    for (genvar k = 0; k < PAR_BYTES; k++) begin : g_par
      assign parity[8*k +: 8] = acc_q[8*(k % 4) +: 8] ^ 8'(k) ^ 8'hA5;
    end
  endgenerate

  always_comb begin
    acc_n  = acc_q;
    tmr_n  = tmr_q;
    run_n  = run_q;
    mdec_n = mdec_q;
    inj_n  = inj_q;
    det_n  = det_q;
    fail_n = fail_q;
    cnt_n  = cnt_q;
    if (clr_acc)          acc_n = '0;
    else if (data_strobe) acc_n = acc_q ^ data_word;
    if (clr_stat) begin
      det_n  = 1'b0;
      fail_n = 1'b0;
      cnt_n  = 2'd0;
    end
    if (start_enc || start_dec) begin
      run_n  = 1'b1;
      tmr_n  = TW'(CODEC_LAT - 1);
      mdec_n = start_dec;
      inj_n  = inj_errs;
    end else if (run_q) begin
      if (tmr_q == '0) begin
        run_n = 1'b0;
        if (mdec_q) begin
          if (inj_q == 3'd0) begin
            det_n = 1'b0;
          end else if (inj_q <= 3'd4) begin
            det_n = 1'b1;
            cnt_n = 2'(inj_q - 3'd1);
          end else begin
            fail_n = 1'b1;
          end
        end
      end else begin
        tmr_n = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tmr_q  <= '0;
      run_q  <= 1'b0;
      mdec_q <= 1'b0;
      inj_q  <= '0;
      det_q  <= 1'b0;
      fail_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      acc_q  <= acc_n;
      tmr_q  <= tmr_n;
      run_q  <= run_n;
      mdec_q <= mdec_n;
      inj_q  <= inj_n;
      det_q  <= det_n;
      fail_q <= fail_n;
      cnt_q  <= cnt_n;
    end
  end

  assign err_detect = det_q;
  assign err_count  = cnt_q;
  assign dec_fail   = fail_q;
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int SUBS = 4,
  parameter int SUBW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_sel,
  input  logic            acc_half,
  input  logic            enc_qual,
  input  logic            codec_done,
  output logic            ready,
  output logic            overrun,
  output logic [CNTW-1:0] idx,
  output logic            buf_we_word,
  output logic            buf_we_half,
  output logic            data_strobe,
  output logic            rd_live,
  output logic            start_enc,
  output logic            start_dec,
  output logic            open_acc,
  output logic            trig_any,
  output logic            par_we,
  output logic [SUBW-1:0] sub_idx
);
  st_e             st_q, st_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            dec_q, dec_n;
  logic            ovr_q, ovr_n;
  logic [SUBW-1:0] sub_q, sub_n;
  logic            is_buf, is_trig, open_ok, enc_ok, dec_ok, wr_ok, rd_ok, bad;

  always_comb begin
    is_buf  = acc_valid && (acc_sel == SEL_BUF);
    is_trig = acc_valid && acc_write && (acc_sel != SEL_BUF);
    open_ok = is_trig && (acc_sel == SEL_OPEN) && (st_q == ST_IDLE || st_q == ST_DRAIN);
    dec_ok  = is_trig && (acc_sel == SEL_DEC)  && (st_q == ST_IDLE || st_q == ST_DRAIN);
    enc_ok  = is_trig && (acc_sel == SEL_ENC)  && (st_q == ST_FILL) && !enc_qual;
    wr_ok   = is_buf && acc_write && (st_q == ST_FILL) &&
              ((cnt_q <= CNTW'(DATA_WORDS) && !acc_half) ||
               (cnt_q == CNTW'(DATA_WORDS + 1) && acc_half));
    rd_ok   = is_buf && !acc_write && (st_q == ST_DRAIN) && (cnt_q < CNTW'(SUB_WORDS));
    bad     = is_buf && !wr_ok && !rd_ok;
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    dec_n = dec_q;
    ovr_n = ovr_q;
    sub_n = sub_q;
    if (open_ok || dec_ok || enc_ok) ovr_n = 1'b0;
    else if (bad)                    ovr_n = 1'b1;
    case (st_q)
      ST_IDLE, ST_DRAIN: begin
        if (open_ok) begin
          st_n  = ST_FILL;
          cnt_n = '0;
        end else if (dec_ok) begin
          st_n  = ST_BUSY;
          dec_n = 1'b1;
        end else if (rd_ok) begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_FILL: begin
        if (enc_ok) begin
          st_n  = ST_BUSY;
          dec_n = 1'b0;
        end else if (wr_ok) begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_BUSY: begin
        if (codec_done) begin
          st_n  = dec_q ? ST_DRAIN : ST_IDLE;
          cnt_n = '0;
          sub_n = (sub_q == SUBW'(SUBS - 1)) ? '0 : sub_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      dec_q <= 1'b0;
      ovr_q <= 1'b0;
      sub_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      dec_q <= dec_n;
      ovr_q <= ovr_n;
      sub_q <= sub_n;
    end
  end

  assign ready       = (st_q == ST_IDLE) || (st_q == ST_DRAIN);
  assign overrun     = ovr_q;
  assign idx         = cnt_q;
  assign buf_we_word = wr_ok && !acc_half;
  assign buf_we_half = wr_ok && acc_half;
  assign data_strobe = wr_ok && (cnt_q < CNTW'(DATA_WORDS));
  assign rd_live     = (st_q == ST_DRAIN) && (cnt_q < CNTW'(SUB_WORDS));
  assign start_enc   = enc_ok;
  assign start_dec   = dec_ok;
  assign open_acc    = open_ok;
  assign trig_any    = open_ok || dec_ok || enc_ok;
  assign par_we      = codec_done && !dec_q && (st_q == ST_BUSY);
  assign sub_idx     = sub_q;
endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int CODEC_LAT  = 16,
  localparam int SUBS      = PAGE_BYTES / 512,
  localparam int SUBW      = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_sel,
  input  logic            acc_half,
  input  logic [31:0]     acc_wdata,
  output logic [31:0]     acc_rdata,
  input  logic [2:0]      inj_errs,
  output logic            ctl_ready,
  output logic            overrun,
  output logic            err_detect,
  output logic [1:0]      err_count,
  output logic            dec_fail,
  output logic [SUBW-1:0] sub_idx
);
  logic [CNTW-1:0]          idx;
  logic                     we_word, we_half, dstb, rd_live;
  logic                     st_enc, st_dec, open_acc, trig_any, par_we, done;
  logic [PAR_BYTES*8-1:0]   parity;
  logic [31:0]              buf_rd;

  sps_ctrl #(.SUBS(SUBS), .SUBW(SUBW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_half(acc_half), .enc_qual(acc_wdata[8]),
    .codec_done(done), .ready(ctl_ready), .overrun(overrun), .idx(idx),
    .buf_we_word(we_word), .buf_we_half(we_half), .data_strobe(dstb),
    .rd_live(rd_live), .start_enc(st_enc), .start_dec(st_dec),
    .open_acc(open_acc), .trig_any(trig_any), .par_we(par_we), .sub_idx(sub_idx)
  );

  sps_codec_stub #(.CODEC_LAT(CODEC_LAT)) u_codec (
    .clk(clk), .rst_n(rst_n), .clr_acc(open_acc), .data_strobe(dstb),
    .data_word(acc_wdata), .start_enc(st_enc), .start_dec(st_dec),
    .inj_errs(inj_errs), .clr_stat(trig_any), .done(done), .parity(parity),
    .err_detect(err_detect), .err_count(err_count), .dec_fail(dec_fail)
  );

  sps_buffer u_buf (
    .clk(clk), .we_word(we_word), .we_half(we_half), .idx(idx),
    .wdata(acc_wdata), .par_we(par_we), .parity(parity), .rdata(buf_rd)
  );

  assign acc_rdata = rd_live ? buf_rd : 32'd0;
endmodule

// File: rtl/sps_seq_chk.sv
module sps_seq_chk #(
  parameter int CODEC_LAT = 16,
  parameter int SUBS      = 4,
  parameter int SUBW      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [1:0]      acc_sel,
  input logic            ctl_ready,
  input logic            overrun,
  input logic            err_detect,
  input logic            dec_fail,
  input logic [SUBW-1:0] sub_idx
);
  logic        dtrk;
  logic [15:0] dcnt;
  logic        dec_go;

  assign dec_go = ctl_ready && acc_valid && acc_write && (acc_sel == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtrk <= 1'b0;
      dcnt <= '0;
    end else if (dec_go) begin
      dtrk <= 1'b1;
      dcnt <= '0;
    end else if (dtrk && !ctl_ready) begin
      dcnt <= dcnt + 1'b1;
    end else if (dtrk && ctl_ready && dcnt != 0) begin
      dtrk <= 1'b0;
    end
  end

  // R4: ready falls right after an accepted decode
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    dec_go |=> !ctl_ready);

  // R4: ready returns after exactly CODEC_LAT low cycles
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (dtrk && ctl_ready && dcnt != 0) |-> (dcnt == 16'(CODEC_LAT)));

  // R6: detect and failure never together
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_detect && dec_fail));

  // R7: overrun only rises after a buffer-port access
  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(acc_valid && acc_sel == 2'd0));

  // R10: subpage index stays inside the page
  a_r10_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sub_idx) < SUBS);
endmodule

bind sps_seq sps_seq_chk #(.CODEC_LAT(CODEC_LAT), .SUBS(SUBS), .SUBW(SUBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_sel), .ctl_ready(ctl_ready), .overrun(overrun),
  .err_detect(err_detect), .dec_fail(dec_fail), .sub_idx(sub_idx)
);

// File: tb/sim_sps_seq.sv
module sim_sps_seq;
  localparam int LAT  = 16;
  localparam int SUBS = 4;

  logic        clk, rst_n, acc_valid, acc_write, acc_half;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata, acc_rdata;
  logic [2:0]  inj_errs;
  logic        ctl_ready, overrun, err_detect, dec_fail;
  logic [1:0]  err_count, sub_idx;

  int checks = 0, fails = 0, cyc = 0, sub_m = 0;
  logic [31:0] xw;

  // {inj, seed, det, cnt, fail}
  localparam logic [38:0] VEC [6] = '{
    {3'd0, 32'h1234_5678, 1'b0, 2'd0, 1'b0},
    {3'd1, 32'hDEAD_BEEF, 1'b1, 2'd0, 1'b0},
    {3'd2, 32'h0F0F_A5A5, 1'b1, 2'd1, 1'b0},
    {3'd3, 32'h8000_0001, 1'b1, 2'd2, 1'b0},
    {3'd4, 32'h5555_AAAA, 1'b1, 2'd3, 1'b0},
    {3'd5, 32'h0000_0000, 1'b0, 2'd0, 1'b1}
  };

  sps_seq u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] s, input logic h, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_sel = s; acc_half = h; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_sel = 2'd0; acc_half = 0;
    #1 d = acc_rdata;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    @(negedge clk);
    while (!ctl_ready && n < 200) begin n++; @(negedge clk); end
  endtask

  function automatic logic [31:0] gen(input logic [31:0] seed, input int i);
    return seed ^ (32'(i) * 32'h0101_0101) ^ {i[7:0], 24'h0};
  endfunction

  function automatic logic [7:0] par(input logic [31:0] x, input int k);
    return x[8*(k%4) +: 8] ^ 8'(k) ^ 8'hA5;
  endfunction

  // fill and encode one subpage; returns data XOR
  task automatic write_sub(input logic [31:0] seed, output logic [31:0] x);
    int n;
    x = 0;
    acc(1, 2'd1, 0, 0);
    for (int i = 0; i < 128; i++) begin
      acc(1, 2'd0, 0, gen(seed, i));
      x ^= gen(seed, i);
    end
    acc(1, 2'd0, 0, ~seed);
    acc(1, 2'd0, 1, {16'h0, seed[15:0] ^ 16'h5A5A});
    acc(1, 2'd2, 0, 0);
    wait_ready(n);
    chk(n == LAT, "R2 encode latency", n, LAT);
    sub_m = (sub_m + 1) % SUBS;
    chk(sub_idx == 2'(sub_m), "R10 sub_idx after encode", sub_idx, sub_m);
  endtask

  task automatic spare_exp(input logic [31:0] seed, input logic [31:0] x, input int w, output logic [31:0] e);
    case (w)
      0: e = ~seed;
      1: e = {par(x,1), par(x,0), seed[15:0] ^ 16'h5A5A};
      2: e = {par(x,5), par(x,4), par(x,3), par(x,2)};
      default: e = {par(x,9), par(x,8), par(x,7), par(x,6)};
    endcase
  endtask

  initial begin
    logic [31:0] d, e, x;
    int n, bad;
    acc_valid = 0; acc_write = 0; acc_sel = 0; acc_half = 0; acc_wdata = 0; inj_errs = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_ready && !overrun && !err_detect && !dec_fail && err_count == 0 && sub_idx == 0,
        "R1 reset outputs", {ctl_ready, overrun, err_detect, dec_fail, err_count, sub_idx}, 32'h80);

    // vector loop: encode, decode with injected count, read back
    for (int v = 0; v < 6; v++) begin
      logic [31:0] seed;
      seed = VEC[v][35:4];
      write_sub(seed, x);
      inj_errs = VEC[v][38:36];
      acc(1, 2'd3, 0, 0);
      wait_ready(n);
      chk(n == LAT, "R4 decode latency", n, LAT);
      sub_m = (sub_m + 1) % SUBS;
      chk(sub_idx == 2'(sub_m), "R10 sub_idx after decode", sub_idx, sub_m);
      chk({err_detect, err_count, dec_fail} == VEC[v][3:0], "R6 status encoding",
          {err_detect, err_count, dec_fail}, VEC[v][3:0]);
      bad = 0;
      for (int i = 0; i < 128; i++) begin
        rd(d);
        if (d !== gen(seed, i)) bad++;
      end
      chk(bad == 0, "R5 data words", bad, 0);
      for (int w = 0; w < 4; w++) begin
        rd(d);
        spare_exp(seed, x, w, e);
        chk(d === e, "R5 spare word", d, e);
      end
      chk({err_detect, err_count, dec_fail} == VEC[v][3:0], "R6 status held",
          {err_detect, err_count, dec_fail}, VEC[v][3:0]);
      chk(!overrun, "R7 no overrun on exact drain", overrun, 0);
    end

    // R7: one read past the end
    rd(d);
    @(negedge clk);
    chk(overrun, "R7 overrun after extra read", overrun, 1);

    // R3 / R9: auto-encode with bit 8 set and a stray decode are ignored
    xw = 32'hC0FF_EE00;
    acc(1, 2'd1, 0, 0);
    chk(!overrun && !err_detect && !dec_fail, "R6 R7 cleared by trigger",
        {overrun, err_detect, dec_fail}, 0);
    for (int i = 0; i < 128; i++) acc(1, 2'd0, 0, gen(xw, i));
    // R8: wrong widths at spare slots
    acc(1, 2'd0, 1, 32'h1111_1111);
    @(negedge clk);
    chk(overrun, "R8 half at word slot", overrun, 1);
    acc(1, 2'd0, 0, ~xw);
    acc(1, 2'd0, 0, 32'h2222_2222);
    acc(1, 2'd0, 1, {16'h0, xw[15:0] ^ 16'h5A5A});
    // R7: write beyond the fill count
    acc(1, 2'd0, 0, 32'h3333_3333);
    @(negedge clk);
    chk(overrun, "R7 extra fill write", overrun, 1);
    acc(1, 2'd2, 0, 32'h100);
    acc(1, 2'd3, 0, 0);
    acc(1, 2'd1, 0, 0);
    repeat (40) @(negedge clk);
    chk(!ctl_ready, "R3 R9 ignored triggers keep ready low", ctl_ready, 0);
    chk(sub_idx == 2'(sub_m), "R9 no step completed", sub_idx, sub_m);
    acc(1, 2'd2, 0, 0);
    wait_ready(n);
    chk(n == LAT, "R2 encode after ignored triggers", n, LAT);
    sub_m = (sub_m + 1) % SUBS;

    x = 0;
    for (int i = 0; i < 128; i++) x ^= gen(xw, i);
    inj_errs = 3'd7;
    acc(1, 2'd3, 0, 0);
    wait_ready(n);
    sub_m = (sub_m + 1) % SUBS;
    chk(dec_fail && !err_detect, "R6 count above five fails", {err_detect, dec_fail}, 1);
    chk(sub_idx == 2'(sub_m), "R10 wrap tracking", sub_idx, sub_m);
    for (int i = 0; i < 10; i++) rd(d);
    // R7: write during drain is ignored; position and data kept
    acc(1, 2'd0, 0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(overrun, "R7 write during drain", overrun, 1);
    rd(d);
    chk(d === gen(xw, 10), "R7 drain position kept", d, gen(xw, 10));
    for (int i = 11; i < 128; i++) rd(d);
    for (int w = 0; w < 4; w++) begin
      rd(d);
      spare_exp(xw, x, w, e);
      chk(d === e, "R8 spare after rejected widths", d, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule